// File: doc/BRIEF.md
# PCIe Completion Error Reporter

This block sits on the application side of a PCIe endpoint and turns one error request into the signalling the endpoint core expects. A request carries a two-bit error kind, a flag that says whether the offending request was non-posted, a flag asking for the TLP header to be logged, and the 128-bit header itself. The request is taken in a single cycle when the block is idle.

When logging is requested, the block first copies the header into the core's error header log. It does this with four 32-bit writes on a local register port. It sends the most significant word first, and each write waits for an acknowledge before the next one starts. If the error answers a non-posted request with completer abort or unsupported request, the block then waits until the application reports that the completion carrying that status has gone out. Only then does it raise the matching completion-error bit for one cycle. The log-header bit is raised in that same cycle when logging was asked for. The core keeps a logged header only for the first error it detects. Building the completion TLP is left to the application.

Top module: `tlp_err_reporter`

## Requirements
- R1: After reset, `busy`, `lmi_wr` and every bit of `cpl_err` are low.
- R2: A request is taken when `req_valid` is high and `busy` is low at a rising edge. `busy` is high from the next cycle through the cycle of the error pulse, and it is low in the cycle after the pulse.
- R3: `req_valid` is ignored while `busy` is high. Such a request causes no register write and no error pulse.
- R4: With `req_log` set, the block makes exactly four writes, in this order: address 0x81C with header[127:96], 0x820 with header[95:64], 0x824 with header[63:32], and 0x828 with header[31:0].
- R5: Each write raises `lmi_wr` for exactly one cycle. `lmi_addr` and `lmi_wdata` then stay unchanged until the error pulse. The next write begins in the cycle after `lmi_ack` is sampled high.
- R6: The error pulse sets exactly one of `cpl_err[5:2]`. Kind 0 (completer abort) sets bit 2, kind 1 (unexpected completion) sets bit 3, kind 2 (unsupported request, posted) sets bit 4, and kind 3 (unsupported request, non-posted) sets bit 5. `cpl_err[1:0]` are always low.
- R7: `cpl_err[6]` is set only together with the error bit, only when `req_log` was set, and only after all four writes have been acknowledged.
- R8: Each error pulse lasts exactly one cycle, and each request produces exactly one pulse.
- R9: For kind 3, or for kind 0 with `req_np` set, the pulse is held back until `cpl_sent` is sampled high while waiting. The pulse then appears in the next cycle. For kinds 1 and 2, `req_np` has no effect.
- R10: Without logging and without a completion wait, no write occurs and the pulse appears in the cycle right after the request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Error request present |
| req_kind | input | 2 | Error kind (0 abort, 1 unexpected completion, 2 UR posted, 3 UR non-posted) |
| req_np | input | 1 | The failing request was non-posted (affects kind 0) |
| req_log | input | 1 | Log the header before signalling |
| req_hdr | input | 128 | TLP header to log |
| busy | output | 1 | Request in progress; new requests refused |
| lmi_addr | output | 12 | Register port address |
| lmi_wdata | output | 32 | Register port write data |
| lmi_wr | output | 1 | One-cycle write strobe |
| lmi_ack | input | 1 | Write acknowledge from the core |
| cpl_sent | input | 1 | The error completion has been sent |
| cpl_err | output | 7 | Completion error bits (2..5 kind, 6 log header) |

## Verification
`busy` rises one cycle after a request is taken. Without logging or waiting, the error pulse is due in that same cycle. With a completion wait, the pulse is due one cycle after `cpl_sent` is sampled. Each write is due one cycle after the previous acknowledge is sampled, and the acknowledge responder is run with delays of one to three cycles. The driver records the cycle number at which it drives each stimulus. A monitor sampling on falling edges stamps every pulse with its cycle number and pops expected writes and pulses from queues, so any early, late, extra or doubled strobe shows up as a mismatch.

// File: rtl/cer_pkg.sv
package cer_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int HDR_W     = 128;
    localparam int ERR_W     = 7;
    localparam int BIT_FIRST = 2;
    localparam int BIT_LOG   = 6;
    localparam int LOG_BASE  = 'h81C;
    localparam int LOG_STEP  = 4;

    typedef enum logic [1:0] {
        EK_ABORT   = 2'd0,
        EK_UNEXP   = 2'd1,
        EK_UR_POST = 2'd2,
        EK_UR_NP   = 2'd3
    } err_kind_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_LOG,
        CS_CPL,
        CS_FIRE
    } ctl_state_t;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_ISSUE,
        WP_WAIT
    } wr_phase_t;

    typedef struct packed {
        err_kind_t          kind;
        logic               np;
        logic               log;
        logic [HDR_W-1:0]   hdr;
    } err_req_t;

    // A completion must precede the strobe when a non-posted request was refused.
    function automatic logic needs_cpl(err_kind_t k, logic np);
        return (k == EK_UR_NP) || ((k == EK_ABORT) && np);
    endfunction

endpackage

// File: rtl/cer_log_writer.sv
module cer_log_writer
    import cer_pkg::*;
#(
    parameter int HW   = HDR_W,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int BASE = LOG_BASE,
    parameter int STEP = LOG_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [HW-1:0] hdr,
    input  logic          ack,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          wr,
    output logic          done
);
    localparam int WORDS = HW / DW;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    wr_phase_t        phase;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    words [WORDS];

    // Word 0 is the most significant slice of the header.
    for (genvar i = 0; i < WORDS; i++) begin : g_slice
        assign words[i] = hdr[HW-1-i*DW -: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= WP_IDLE;
            idx   <= '0;
        end else begin
            case (phase)
                WP_IDLE: if (start) begin
                    phase <= WP_ISSUE;
                    idx   <= '0;
                end
                WP_ISSUE: phase <= WP_WAIT;
                WP_WAIT: if (ack) begin
                    if (idx == LAST) begin
                        phase <= WP_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        phase <= WP_ISSUE;
                    end
                end
                default: phase <= WP_IDLE;
            endcase
        end
    end

    assign wr    = (phase == WP_ISSUE);
    assign addr  = AW'(BASE) + AW'(idx) * AW'(STEP);
    assign wdata = words[idx];
    assign done  = (phase == WP_WAIT) && ack && (idx == LAST);

    // R5: strobe lasts one cycle
    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr |=> !wr);

    // R5: address and data held while the acknowledge is outstanding
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == WP_WAIT && !ack) |=> ($stable(addr) && $stable(wdata)));

    // R4: first write of a sequence goes to the base address
    p_first_base_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == WP_IDLE && start) |=> (wr && addr == AW'(BASE)));

endmodule

// File: rtl/cer_err_encoder.sv
module cer_err_encoder
    import cer_pkg::*;
#(
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  err_kind_t     kind,
    input  logic          log,
    output logic [EW-1:0] cpl_err
);
    localparam int KINDS = 4;

    for (genvar i = 0; i < KINDS; i++) begin : g_kind
        assign cpl_err[BIT_FIRST+i] = fire && (kind == err_kind_t'(i));
    end
    assign cpl_err[BIT_FIRST-1:0] = '0;
    assign cpl_err[BIT_LOG]       = fire && log;

    // R6: at most one kind bit at a time
    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cpl_err[BIT_FIRST+KINDS-1:BIT_FIRST]));

    // R7: log-header bit never stands alone
    p_log_pair_r7: assert property (@(posedge clk) disable iff (rst)
        cpl_err[BIT_LOG] |-> ($countones(cpl_err[BIT_FIRST+KINDS-1:BIT_FIRST]) == 1));

endmodule

// File: rtl/tlp_err_reporter.sv
module tlp_err_reporter
    import cer_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int HW = HDR_W,
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_np,
    input  logic          req_log,
    input  logic [HW-1:0] req_hdr,
    output logic          busy,
    output logic [AW-1:0] lmi_addr,
    output logic [DW-1:0] lmi_wdata,
    output logic          lmi_wr,
    input  logic          lmi_ack,
    input  logic          cpl_sent,
    output logic [EW-1:0] cpl_err
);
    ctl_state_t state, state_nx;
    err_req_t   held;
    logic       accept;
    logic       log_done;
    logic       held_wait;
    logic       req_wait;

    assign accept    = req_valid && (state == CS_IDLE);
    assign held_wait = needs_cpl(held.kind, held.np);
    assign req_wait  = needs_cpl(err_kind_t'(req_kind), req_np);
    assign busy      = (state != CS_IDLE);

    always_comb begin
        state_nx = state;
        case (state)
            CS_IDLE: if (accept) begin
                if (req_log)       state_nx = CS_LOG;
                else if (req_wait) state_nx = CS_CPL;
                else               state_nx = CS_FIRE;
            end
            CS_LOG:  if (log_done) state_nx = held_wait ? CS_CPL : CS_FIRE;
            CS_CPL:  if (cpl_sent) state_nx = CS_FIRE;
            CS_FIRE: state_nx = CS_IDLE;
            default: state_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            held  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                held.kind <= err_kind_t'(req_kind);
                held.np   <= req_np;
                held.log  <= req_log;
                held.hdr  <= req_hdr;
            end
        end
    end

    cer_log_writer #(
        .HW(HW), .DW(DW), .AW(AW), .BASE(LOG_BASE), .STEP(LOG_STEP)
    ) u_writer (
        .clk   (clk),
        .rst   (rst),
        .start (accept && req_log),
        .hdr   (held.hdr),
        .ack   (lmi_ack),
        .addr  (lmi_addr),
        .wdata (lmi_wdata),
        .wr    (lmi_wr),
        .done  (log_done)
    );

    cer_err_encoder #(.EW(EW)) u_enc (
        .clk     (clk),
        .rst     (rst),
        .fire    (state == CS_FIRE),
        .kind    (held.kind),
        .log     (held.log),
        .cpl_err (cpl_err)
    );

    // R8: error pulse lasts one cycle
    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (cpl_err != '0) |=> (cpl_err == '0));

    // R2: busy drops right after the pulse
    p_busy_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (cpl_err != '0) |=> !busy);

    // R2: register writes only happen inside a request
    p_wr_busy_r2: assert property (@(posedge clk) disable iff (rst)
        lmi_wr |-> busy);

    // R9: gated pulse follows the completion-sent handshake
    p_cpl_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ((cpl_err[5:2] != '0) && held_wait) |-> $past(cpl_sent));

endmodule

// File: tb/tb_tlp_err_reporter.sv
module tb_tlp_err_reporter;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_kind = '0;
    logic         req_np = 1'b0;
    logic         req_log = 1'b0;
    logic [127:0] req_hdr = '0;
    logic         busy;
    logic [11:0]  lmi_addr;
    logic [31:0]  lmi_wdata;
    logic         lmi_wr;
    logic         lmi_ack = 1'b0;
    logic         cpl_sent = 1'b0;
    logic [6:0]   cpl_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_delay = 1;
    int pulse_cnt = 0;
    int pulse_cyc = -1;
    int wr_since = 0;
    logic        track = 1'b0;
    logic [43:0] held_wr = '0;
    logic [43:0] wq [$];
    logic [6:0]  eq [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tlp_err_reporter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_np(req_np), .req_log(req_log), .req_hdr(req_hdr), .busy(busy),
        .lmi_addr(lmi_addr), .lmi_wdata(lmi_wdata), .lmi_wr(lmi_wr),
        .lmi_ack(lmi_ack), .cpl_sent(cpl_sent), .cpl_err(cpl_err)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Acknowledge responder
    initial begin
        int pend = 0;
        forever begin
            @(negedge clk);
            lmi_ack = 1'b0;
            if (lmi_wr) pend = ack_delay;
            else if (pend > 0) begin
                pend--;
                if (pend == 0) lmi_ack = 1'b1;
            end
        end
    end

    // Monitor: pops expected writes and pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (lmi_wr) begin
                if (wq.size() == 0) check(1'b0, "R3 unexpected write", {52'd0, lmi_addr}, 64'd0);
                else begin
                    logic [43:0] e;
                    e = wq.pop_front();
                    check({lmi_addr, lmi_wdata} == e, "R4 write addr/data", {20'd0, lmi_addr, lmi_wdata}, {20'd0, e});
                end
                held_wr = {lmi_addr, lmi_wdata};
                track = 1'b1;
                wr_since++;
            end else if (track) begin
                check({lmi_addr, lmi_wdata} == held_wr, "R5 hold", {20'd0, lmi_addr, lmi_wdata}, {20'd0, held_wr});
            end
            if (cpl_err != '0) begin
                pulse_cnt++;
                pulse_cyc = cyc;
                if (eq.size() == 0) check(1'b0, "R8 extra pulse", {57'd0, cpl_err}, 64'd0);
                else begin
                    logic [6:0] e;
                    e = eq.pop_front();
                    check(cpl_err == e, "R6 error bits", {57'd0, cpl_err}, {57'd0, e});
                end
                if (cpl_err[6]) check(wr_since == 4, "R7 writes before log bit", 64'(wr_since), 64'd4);
                wr_since = 0;
                track = 1'b0;
            end
        end
    end

    task automatic do_req(input logic [1:0] k, input logic np, input logic lg,
                          input logic [127:0] h, input int dly, input logic poke);
        logic w;
        logic [6:0] ev;
        int c0, c1, pc, guard;
        w = (k == 2'd3) || (k == 2'd0 && np);
        ack_delay = dly;
        guard = 0;
        while (busy && guard < 100) begin @(negedge clk); guard++; end
        if (lg) begin
            for (int i = 0; i < 4; i++)
                wq.push_back({12'h81C + 12'(4*i), h[127-32*i -: 32]});
        end
        ev = '0;
        ev[2+k] = 1'b1;
        ev[6] = lg;
        eq.push_back(ev);
        pc = pulse_cnt;
        req_valid = 1'b1; req_kind = k; req_np = np; req_log = lg; req_hdr = h;
        c0 = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        if (poke) begin
            req_valid = 1'b1; req_kind = k ^ 2'd1; req_log = 1'b0; req_np = 1'b0;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        if (w) begin
            guard = 0;
            while (wq.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
            repeat (12) @(negedge clk);
            #1;
            check(pulse_cnt == pc, "R9 pulse held before completion", 64'(pulse_cnt), 64'(pc));
            check(busy == 1'b1, "R9 busy while waiting", 64'(busy), 64'd1);
            cpl_sent = 1'b1;
            c1 = cyc;
            @(negedge clk);
            cpl_sent = 1'b0;
            #1;
            check(pulse_cnt == pc + 1, "R9 pulse after completion", 64'(pulse_cnt), 64'(pc + 1));
            check(pulse_cyc == c1 + 1, "R9 pulse cycle", 64'(pulse_cyc), 64'(c1 + 1));
        end else if (!lg) begin
            check(pulse_cnt == pc + 1, "R10 immediate pulse", 64'(pulse_cnt), 64'(pc + 1));
            check(pulse_cyc == c0 + 1, "R10 pulse cycle", 64'(pulse_cyc), 64'(c0 + 1));
        end else begin
            guard = 0;
            while (busy && guard < 200) begin @(negedge clk); guard++; end
            #1;
            check(pulse_cnt == pc + 1, "R7 logged pulse", 64'(pulse_cnt), 64'(pc + 1));
        end
        @(negedge clk);
        #1;
        check(busy == 1'b0, "R2 busy low after pulse", 64'(busy), 64'd0);
        check(wq.size() == 0 && eq.size() == 0, "R8 scoreboard drained",
              64'(wq.size() + eq.size()), 64'd0);
        repeat (3) @(negedge clk);
        check(pulse_cnt == pc + 1, "R3 no extra pulse", 64'(pulse_cnt), 64'(pc + 1));
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(cpl_err == '0, "R1 cpl_err", 64'(cpl_err), 64'd0);
        check(lmi_wr == 1'b0, "R1 lmi_wr", 64'(lmi_wr), 64'd0);
        @(negedge clk);
        do_req(2'd1, 1'b1, 1'b0, 128'h0, 1, 1'b0);   // R9: np ignored for kind 1
        do_req(2'd2, 1'b1, 1'b0, 128'h0, 1, 1'b0);   // R9: np ignored for kind 2
        do_req(2'd0, 1'b0, 1'b0, 128'h0, 1, 1'b0);   // R10
        do_req(2'd0, 1'b1, 1'b0, 128'h0, 1, 1'b0);   // R9 abort non-posted
        do_req(2'd3, 1'b0, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1, 1'b0);
        do_req(2'd2, 1'b0, 1'b1, 128'hDEAD_BEEF_CAFE_F00D_1111_2222_3333_4444, 3, 1'b1); // R3
        do_req(2'd1, 1'b0, 1'b1, 128'hA5A5_A5A5_5A5A_5A5A_FFFF_0000_0000_FFFF, 2, 1'b0);
        do_req(2'd0, 1'b1, 1'b1, 128'h8000_0001_4000_0002_2000_0004_1000_0008, 2, 1'b0);
        do_req(2'd3, 1'b1, 1'b0, 128'h0, 1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule